// File: doc/BRIEF.md
# GPIO Port Controller

This block runs one general-purpose I/O port of parameterised width, eight pins by default. A small register bus controls it. Three registers sit behind the bus. The direction register decides which pins drive. The output-value register sets the level driven on output pins; on input pins the same bit requests a weak pull-up. The pin-level register is read-only and returns the synchronised pad inputs. A global pull-up disable input turns off every pull-up at once.

Software can change one pin without a read-modify-write. A bit-operation write sets or clears a single indexed bit of the direction or output-value register and leaves all other bits as they were. Each pin also has an override input. When the override is asserted, a peripheral supplies that pin's output value and direction. The pin's neighbours keep their normal register-driven behaviour. The pad itself sits outside the block and is modelled as separate input, output, output-enable and pull-up-enable signals.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and output-value registers hold all zeros, so pad_oe and pad_pu are all zero.
- R2: A full write (bus_wr=1, bus_bitop=0) to address 1 stores bus_wdata in the direction register, and one to address 2 stores it in the output-value register. Both registers read back their stored value.
- R3: Any write to address 0 (pin levels), full or single-bit, leaves the direction and output-value registers unchanged.
- R4: A bit-operation write (bus_wr=1, bus_bitop=1) to address 1 or 2 sets bit bus_bitidx when bus_bitset=1 and clears it when bus_bitset=0. Every other bit of that register is unchanged.
- R5: For a pin whose override is off, pad_oe equals its direction bit (1 = output) and pad_out equals its output-value bit.
- R6: pad_pu for a pin is 1 exactly when its effective output enable is 0, its output-value bit is 1 and pu_disable is 0.
- R7: While pu_disable is 1, every bit of pad_pu is 0.
- R8: Reading address 0 returns pad_in as it was sampled two rising clock edges earlier, through a two-stage synchroniser.
- R9: While alt_en[n] is 1, pad_oe[n] equals alt_dir[n] and pad_out[n] equals alt_out[n]. Pins with alt_en low are unaffected.
- R10: bus_rdata is zero while bus_rd is 0, and reading address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0 pin levels, 1 direction, 2 output value, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; the read data is combinational |
| bus_wdata | input | WIDTH | Write data for full writes |
| bus_bitop | input | 1 | 1 selects a single-bit write |
| bus_bitidx | input | $clog2(WIDTH) | Bit index for a single-bit write |
| bus_bitset | input | 1 | 1 sets, 0 clears the indexed bit |
| bus_rdata | output | WIDTH | Read data |
| pu_disable | input | 1 | Global pull-up disable |
| alt_en | input | WIDTH | Per-pin override enable |
| alt_out | input | WIDTH | Per-pin override output value |
| alt_dir | input | WIDTH | Per-pin override direction (1 = drive) |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad output values |
| pad_oe | output | WIDTH | Pad output enables |
| pad_pu | output | WIDTH | Pad pull-up enables |

## Verification
A register write is visible on bus_rdata, pad_oe, pad_out and pad_pu from the first rising edge after the strobe. Override and pull-up-disable inputs act on the pad outputs in the same cycle, with no clock edge in between. The pin-level read trails pad_in by two rising edges. The bench changes inputs on falling edges and samples all outputs shortly afterwards, before the next rising edge. A reference model, clocked on the same rising edges, holds the register contents and a two-entry history of pad_in, so each expected value already includes the latency its path has. A directed step reads the pin register after one edge and again after two edges, which pins down the exact synchroniser depth.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_PINS = 2'd0,
        A_DIR  = 2'd1,
        A_VAL  = 2'd2,
        A_RSVD = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned IDX_W = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              bitop,
    input  logic [IDX_W-1:0]  bitidx,
    input  logic              bitset,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  val_q
);

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] val;
    } regs_t;

    regs_t            st_d, st_q;
    logic [WIDTH-1:0] bit_mask;

    // New register contents for either a full write or a single-bit write
    function automatic logic [WIDTH-1:0] apply_write(input logic [WIDTH-1:0] old);
        if (!bitop)      return wdata;
        else if (bitset) return old | bit_mask;
        else             return old & ~bit_mask;
    endfunction

    always_comb begin
        bit_mask = {{(WIDTH-1){1'b0}}, 1'b1} << bitidx;
        st_d     = st_q;
        if (wr) begin
            case (reg_addr_e'(addr))
                A_DIR:   st_d.dir = apply_write(st_q.dir);
                A_VAL:   st_d.val = apply_write(st_q.val);
                default: ;  // pin levels and unused slot take no writes
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_q = st_q.dir;
    assign val_q = st_q.val;

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl (
    input  logic dir_bit,
    input  logic val_bit,
    input  logic pu_off_all,
    input  logic ovr_en,
    input  logic ovr_out,
    input  logic ovr_dir,
    output logic oe,
    output logic out,
    output logic pu
);

    logic oe_eff;

    always_comb begin
        oe_eff = ovr_en ? ovr_dir : dir_bit;
        oe     = oe_eff;
        out    = ovr_en ? ovr_out : val_bit;
        pu     = !oe_eff && val_bit && !pu_off_all;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned IDX_W      = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_bitop,
    input  logic [IDX_W-1:0]  bus_bitidx,
    input  logic              bus_bitset,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              pu_disable,
    input  logic [WIDTH-1:0]  alt_en,
    input  logic [WIDTH-1:0]  alt_out,
    input  logic [WIDTH-1:0]  alt_dir,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu
);

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] val_q;
    logic [WIDTH-1:0] pins_q;
    logic [WIDTH-1:0] rd_mux;

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .bitop  (bus_bitop),
        .bitidx (bus_bitidx),
        .bitset (bus_bitset),
        .dir_q  (dir_q),
        .val_q  (val_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_q   (pins_q)
    );

    for (genvar n = 0; n < WIDTH; n++) begin : g_pin
        gpio_pin_ctl u_pin (
            .dir_bit    (dir_q[n]),
            .val_bit    (val_q[n]),
            .pu_off_all (pu_disable),
            .ovr_en     (alt_en[n]),
            .ovr_out    (alt_out[n]),
            .ovr_dir    (alt_dir[n]),
            .oe         (pad_oe[n]),
            .out        (pad_out[n]),
            .pu         (pad_pu[n])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (bus_rd) begin
            case (reg_addr_e'(bus_addr))
                A_PINS:  rd_mux = pins_q;
                A_DIR:   rd_mux = dir_q;
                A_VAL:   rd_mux = val_q;
                default: rd_mux = '0;
            endcase
        end
    end

    assign bus_rdata = rd_mux;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned IDX_W = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             bus_bitop,
    input logic [IDX_W-1:0] bus_bitidx,
    input logic [WIDTH-1:0] bus_rdata,
    input logic             pu_disable,
    input logic [WIDTH-1:0] alt_en,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_pu,
    input logic [WIDTH-1:0] dir_q,
    input logic [WIDTH-1:0] val_q,
    input logic [WIDTH-1:0] pins_q
);

    logic [WIDTH-1:0] idx_mask;
    assign idx_mask = {{(WIDTH-1){1'b0}}, 1'b1} << bus_bitidx;

    a_r3_pin_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> ($stable(dir_q) && $stable(val_q)));

    a_r4_dir_bitop_local: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_bitop && bus_addr == 2'd1) |=>
            (((dir_q ^ $past(dir_q)) & ~$past(idx_mask)) == '0 && $stable(val_q)));

    a_r4_val_bitop_local: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_bitop && bus_addr == 2'd2) |=>
            (((val_q ^ $past(val_q)) & ~$past(idx_mask)) == '0 && $stable(dir_q)));

    a_r5_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        ((~alt_en & (pad_oe ^ dir_q)) == '0));

    a_r6_no_pullup_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0));

    a_r7_global_pullup_off: assert property (@(posedge clk) disable iff (!rst_n)
        pu_disable |-> (pad_pu == '0));

    a_r8_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (pins_q == $past(pad_in, 2)));

    a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_bitop  (bus_bitop),
    .bus_bitidx (bus_bitidx),
    .bus_rdata  (bus_rdata),
    .pu_disable (pu_disable),
    .alt_en     (alt_en),
    .pad_in     (pad_in),
    .pad_oe     (pad_oe),
    .pad_pu     (pad_pu),
    .dir_q      (dir_q),
    .val_q      (val_q),
    .pins_q     (pins_q)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0, bus_bitop = 1'b0, bus_bitset = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [2:0]   bus_bitidx = '0;
    logic [W-1:0] bus_rdata;
    logic         pu_disable = 1'b0;
    logic [W-1:0] alt_en = '0, alt_out = '0, alt_dir = '0, pad_in = '0;
    logic [W-1:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_bitop(bus_bitop), .bus_bitidx(bus_bitidx),
        .bus_bitset(bus_bitset), .bus_rdata(bus_rdata), .pu_disable(pu_disable),
        .alt_en(alt_en), .alt_out(alt_out), .alt_dir(alt_dir), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // Reference model of the requirements
    logic [W-1:0] m_dir, m_val, m_h1, m_h2;

    function automatic logic [W-1:0] wr_result(input logic [W-1:0] old);
        logic [W-1:0] m;
        m = 8'(1) << bus_bitidx;
        if (!bus_bitop) return bus_wdata;
        return bus_bitset ? (old | m) : (old & ~m);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir <= '0; m_val <= '0; m_h1 <= '0; m_h2 <= '0;
        end else begin
            if (bus_wr && bus_addr == 2'd1) m_dir <= wr_result(m_dir);
            if (bus_wr && bus_addr == 2'd2) m_val <= wr_result(m_val);
            m_h1 <= pad_in;
            m_h2 <= m_h1;
        end
    end

    function automatic logic [W-1:0] exp_oe();
        return (alt_en & alt_dir) | (~alt_en & m_dir);
    endfunction
    function automatic logic [W-1:0] exp_out();
        return (alt_en & alt_out) | (~alt_en & m_val);
    endfunction
    function automatic logic [W-1:0] exp_pu();
        return pu_disable ? '0 : (~exp_oe() & m_val);
    endfunction
    function automatic logic [W-1:0] exp_rd();
        if (!bus_rd) return '0;
        case (bus_addr)
            2'd0: return m_h2;
            2'd1: return m_dir;
            2'd2: return m_val;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(alt_en != 0 ? "R9 oe" : "R5 oe", pad_oe, exp_oe());
        chk(alt_en != 0 ? "R9 out" : "R5 out", pad_out, exp_out());
        chk(pu_disable ? "R7 pu" : "R6 pu", pad_pu, exp_pu());
        chk(!bus_rd ? "R10 idle" : bus_addr == 2'd0 ? "R8 pins" :
            bus_addr == 2'd3 ? "R10 unused" : "R2 read", bus_rdata, exp_rd());
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; bus_bitop = 0;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_bitop = 0; bus_wr = 1; bus_rd = 0;
        @(negedge clk); idle();
    endtask

    task automatic do_bit(input logic [1:0] a, input logic [2:0] idx, input logic setv);
        @(negedge clk);
        bus_addr = a; bus_bitidx = idx; bus_bitset = setv; bus_bitop = 1; bus_wr = 1; bus_rd = 0;
        @(negedge clk); idle();
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        bus_addr = a; bus_rd = 1; #1; v = bus_rdata; bus_rd = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'd20240611));
        pad_in = 8'h5A;
        repeat (4) @(negedge clk);
        #1;
        chk("R1 oe in reset", pad_oe, 8'h00);
        chk("R1 pu in reset", pad_pu, 8'h00);
        rst_n = 1;
        @(negedge clk);
        rd(2'd1, v); chk("R1 dir", v, 8'h00);
        rd(2'd2, v); chk("R1 val", v, 8'h00);

        do_write(2'd2, 8'hA5);
        do_write(2'd1, 8'h0F);
        #1;
        chk("R5 oe", pad_oe, 8'h0F);
        chk("R5 out", pad_out, 8'hA5);
        chk("R6 pu", pad_pu, 8'hA0);
        rd(2'd1, v); chk("R2 dir", v, 8'h0F);
        rd(2'd2, v); chk("R2 val", v, 8'hA5);

        pu_disable = 1; #1;
        chk("R7 pu", pad_pu, 8'h00);
        pu_disable = 0;

        do_bit(2'd1, 3'd7, 1'b1);
        rd(2'd1, v); chk("R4 set dir", v, 8'h8F);
        chk("R6 pu after set", pad_pu, 8'h20);
        do_bit(2'd2, 3'd0, 1'b0);
        rd(2'd2, v); chk("R4 clear val", v, 8'hA4);
        rd(2'd1, v); chk("R4 dir kept", v, 8'h8F);

        do_write(2'd0, 8'hFF);
        do_bit(2'd0, 3'd3, 1'b0);
        rd(2'd1, v); chk("R3 dir kept", v, 8'h8F);
        rd(2'd2, v); chk("R3 val kept", v, 8'hA4);

        alt_en = 8'h01; alt_dir = 8'h00; alt_out = 8'h01; #1;
        chk("R9 oe", pad_oe, 8'h8E);
        chk("R9 out", pad_out, 8'hA5);
        chk("R9 pu", pad_pu, 8'h20);
        alt_dir = 8'h01; alt_out = 8'h00; #1;
        chk("R9 oe drive", pad_oe, 8'h8F);
        chk("R9 out drive", pad_out, 8'hA4);
        alt_en = 0; alt_dir = 0; alt_out = 0;

        @(negedge clk); pad_in = 8'h3C;
        repeat (3) @(negedge clk);
        rd(2'd0, v); chk("R8 settled", v, 8'h3C);
        @(negedge clk); pad_in = 8'hC3;
        @(negedge clk); rd(2'd0, v); chk("R8 one edge", v, 8'h3C);
        @(negedge clk); rd(2'd0, v); chk("R8 two edges", v, 8'hC3);

        bus_addr = 2'd1; bus_rd = 0; #1;
        chk("R10 idle", bus_rdata, 8'h00);
        rd(2'd3, v); chk("R10 unused", v, 8'h00);

        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            bus_wr     = ($urandom % 3) == 0;
            bus_addr   = 2'($urandom);
            bus_bitop  = $urandom % 2;
            bus_bitidx = 3'($urandom);
            bus_bitset = $urandom % 2;
            bus_wdata  = 8'($urandom);
            bus_rd     = ($urandom % 4) != 0;
            pu_disable = ($urandom % 5) == 0;
            alt_en     = 8'($urandom) & 8'($urandom) & 8'($urandom);
            alt_out    = 8'($urandom);
            alt_dir    = 8'($urandom);
            if ($urandom % 2) pad_in = 8'($urandom);
            #1;
            check_all();
        end

        @(negedge clk); idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule